// File: doc/BRIEF.md
# On-chip extension RAM bus slave

This block sits on an internal system bus and owns a 2 KB RAM, arranged as 1024 words of 16 bits, mapped into a fixed 2 KB window (byte addresses 0xE000 to 0xE7FF of a 24-bit space). Every request the bus master presents is decoded against that window and against a global enable flag. An enabled in-window request is served by the local RAM in a fixed number of clocks, with no wait states and no activity on the external side. Every other request is handed unchanged to an external-bus request port for an external controller to carry out.

The enable flag is cleared by reset. While it is clear, the window does not exist and its addresses belong to external memory. Software sets the flag through a dedicated configuration input during start-up. Both 16-bit word accesses and 8-bit byte accesses are supported, for reads and for writes.

Top module: `xram_slave`

## Requirements
- R1: After reset the enable flag is clear, and `ack_o` and `ext_req_o` are low.
- R2: An address is in the window when `addr_i[23:11]` equals `13'h001C`. Only an in-window request made while the flag is set is served locally.
- R3: The flag is loaded from `cfg_en_i` at a clock edge where `cfg_we_i` is high. A request sampled at that same edge is still decoded with the previous flag value.
- R4: A request that is out of the window, or made while the flag is clear, raises `ext_req_o` for exactly the cycle after its sampling edge. `ext_addr_o`, `ext_we_o`, `ext_byte_o` and `ext_wdata_o` carry the request's fields unchanged, and no `ack_o` follows.
- R5: A local request raises `ack_o` for exactly one cycle. That cycle is `ACC_CLKS` (default 2, that is 4 clock phases) edges after the sampling edge, with no wait state. `ext_req_o` stays low for the whole access.
- R6: A word access (`byte_i`=0) uses word index `addr_i[10:1]` and ignores `addr_i[0]`. A word write stores all 16 bits, and a word read returns the stored word on `rdata_o` during the `ack_o` cycle.
- R7: A byte write (`byte_i`=1) stores `wdata_i[7:0]` into the low lane (bits 7:0) when `addr_i[0]`=0, or into the high lane (bits 15:8) when `addr_i[0]`=1. The other lane of that word is unchanged.
- R8: A byte read returns the lane selected by `addr_i[0]` on `rdata_o[7:0]`, with `rdata_o[15:8]` zero.
- R9: `req_i` is ignored from the sampling edge of a local request up to and including the edge that ends its `ack_o` cycle. Such a request neither changes the RAM nor raises `ext_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load strobe for the enable flag |
| cfg_en_i | input | 1 | New enable flag value |
| req_i | input | 1 | Request strobe, one cycle per request |
| we_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| ack_o | output | 1 | Local access complete |
| rdata_o | output | 16 | Local read data, valid with ack_o |
| ext_req_o | output | 1 | Forwarded request strobe |
| ext_we_o | output | 1 | Forwarded write flag |
| ext_byte_o | output | 1 | Forwarded size flag |
| ext_addr_o | output | 24 | Forwarded address |
| ext_wdata_o | output | 16 | Forwarded write data |

## Verification
A configuration write and a request can land on the same clock edge. Only the sampled flag decides whether that request is routed locally or externally. The bench presents an in-window request in the same cycle that sets the flag, and expects it on the external port. It then expects the very next request to be served locally, and does the same when the flag is cleared. Local service and forwarding can also collide when a request arrives during a local access. The bench judges that case by the absence of an external strobe and by an unchanged RAM word read back afterwards.

// File: rtl/xram_pkg.sv
package xram_pkg;
  typedef enum logic {
    ACC_WORD = 1'b0,
    ACC_BYTE = 1'b1
  } acc_size_e;
endpackage

// File: rtl/xram_decode.sv
module xram_decode #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'h00E000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:OFF_W];

  logic [OFF_W-1:0] unused_off;
  assign unused_off = addr_i[OFF_W-1:0];

  assign hit_o = (addr_i[ADDR_W-1:OFF_W] == WIN_TAG);
endmodule

// File: rtl/xram_ctrl.sv
module xram_ctrl #(
  parameter int unsigned ACC_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o,
  output logic fire_o,
  output logic ack_o
);
  localparam int unsigned CNT_W = (ACC_CLKS > 2) ? $clog2(ACC_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CLKS - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_LOAD;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign busy_o = active_q;
  // RAM is touched on the last edge before the ack cycle
  assign fire_o = active_q && (cnt_q == CNT_W'(1));
  assign ack_o  = active_q && (cnt_q == '0);
endmodule

// File: rtl/xram_store.sv
module xram_store #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk_i,
  input  logic                      en_i,
  input  logic [DATA_W/8-1:0]       lane_we_i,
  input  logic [$clog2(DEPTH)-1:0]  idx_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int unsigned LANES = DATA_W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (lane_we_i[l]) mem[idx_i] <= wdata_i[l*8 +: 8];
        rd_q <= mem[idx_i];
      end
    end

    assign rdata_o[l*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/xram_slave.sv
module xram_slave
  import xram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned ACC_CLKS = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'h00E000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic              ext_byte_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned OFF_W = IDX_W + SEL_W;

  logic en_q;
  logic hit, busy, fire, accept, local_go, fwd_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (cfg_we_i) en_q <= cfg_en_i;
  end

  xram_decode #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  assign accept   = req_i && !busy;
  assign local_go = accept && en_q && hit;
  assign fwd_go   = accept && !(en_q && hit);

  xram_ctrl #(.ACC_CLKS(ACC_CLKS)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (local_go),
    .busy_o(busy),
    .fire_o(fire),
    .ack_o (ack_o)
  );

  // captured local request
  logic [IDX_W-1:0]  idx_q;
  logic [SEL_W-1:0]  sel_q;
  acc_size_e         size_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      sel_q   <= '0;
      size_q  <= ACC_WORD;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (local_go) begin
      idx_q   <= addr_i[SEL_W +: IDX_W];
      sel_q   <= addr_i[SEL_W-1:0];
      size_q  <= byte_i ? ACC_BYTE : ACC_WORD;
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] lane_wdata;
  logic [DATA_W-1:0] ram_rdata;

  for (genvar l = 0; l < LANES; l++) begin : g_wr
    assign lane_we[l] = we_q && ((size_q == ACC_WORD) || (sel_q == SEL_W'(l)));
    assign lane_wdata[l*8 +: 8] = (size_q == ACC_BYTE) ? wdata_q[7:0] : wdata_q[l*8 +: 8];
  end

  xram_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .en_i     (fire),
    .lane_we_i(lane_we),
    .idx_i    (idx_q),
    .wdata_i  (lane_wdata),
    .rdata_o  (ram_rdata)
  );

  always_comb begin
    if (size_q == ACC_BYTE) begin
      rdata_o = '0;
      rdata_o[7:0] = ram_rdata[sel_q*8 +: 8];
    end else begin
      rdata_o = ram_rdata;
    end
  end

  // external request port, one registered strobe per forwarded request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_req_o   <= 1'b0;
      ext_we_o    <= 1'b0;
      ext_byte_o  <= 1'b0;
      ext_addr_o  <= '0;
      ext_wdata_o <= '0;
    end else begin
      ext_req_o <= fwd_go;
      if (fwd_go) begin
        ext_we_o    <= we_i;
        ext_byte_o  <= byte_i;
        ext_addr_o  <= addr_i;
        ext_wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/xram_slave_chk.sv
module xram_slave_chk #(
  parameter int unsigned ACC_CLKS = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic cfg_we_i,
  input logic en_q,
  input logic local_go,
  input logic ack_o,
  input logic ext_req_o
);
  localparam int unsigned CW = $clog2(ACC_CLKS + 1) + 1;

  logic [CW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lat_q <= '0;
    else if (ack_o)         lat_q <= '0;
    else if (local_go)      lat_q <= CW'(1);
    else if (lat_q != '0)   lat_q <= lat_q + 1'b1;
  end

  AST_ACK_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o == (lat_q == CW'(ACC_CLKS)));                                  // R5

  AST_NO_EXT_ON_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !ext_req_o);                                               // R5

  AST_EXT_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> $past(req_i));                                         // R4

  AST_LOCAL_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_go |-> en_q);                                                  // R2

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_we_i) |-> $stable(en_q));                                 // R3

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!en_q && !ack_o);                         // R1
    end
  end
endmodule

bind xram_slave xram_slave_chk #(.ACC_CLKS(ACC_CLKS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .cfg_we_i (cfg_we_i),
  .en_q     (en_q),
  .local_go (local_go),
  .ack_o    (ack_o),
  .ext_req_o(ext_req_o)
);

// File: tb/sim_xram_slave.sv
`timescale 1ns/1ps
module sim_xram_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0;
  logic        req = 1'b0, we = 1'b0, bsel = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ack, ext_req, ext_we, ext_byte;
  logic [15:0] rdata, ext_wdata;
  logic [23:0] ext_addr;

  always #2 clk = ~clk;

  xram_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .req_i(req), .we_i(we), .byte_i(bsel), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata), .ext_req_o(ext_req), .ext_we_o(ext_we),
    .ext_byte_o(ext_byte), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata)
  );

  int checks = 0, errors = 0;
  logic [15:0] model [1024];

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [15:0] pat(int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  // called at a negedge; returns at a negedge with the bus idle
  task automatic acc(bit w, bit b, logic [23:0] a, logic [15:0] wd,
                     bit exp_local, logic [15:0] exp_rd, string tag);
    req = 1'b1; we = w; bsel = b; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    chk(ack == 1'b0, {tag, " R5 early ack"}, 32'(ack), 0);
    chk(ext_req == !exp_local, {tag, " R4 ext strobe"}, 32'(ext_req), 32'(!exp_local));
    if (!exp_local)
      chk(ext_addr == a && ext_we == w && ext_byte == b && ext_wdata == wd,
          {tag, " R4 ext fields"}, {ext_addr[15:0], ext_wdata}, {a[15:0], wd});
    @(negedge clk);
    chk(ext_req == 1'b0, {tag, " R5 ext idle"}, 32'(ext_req), 0);
    chk(ack == exp_local, {tag, " R5 ack"}, 32'(ack), 32'(exp_local));
    if (exp_local && !w)
      chk(rdata == exp_rd, {tag, " R6 R8 rdata"}, 32'(rdata), 32'(exp_rd));
    @(negedge clk);
    chk(ack == 1'b0, {tag, " R5 single ack"}, 32'(ack), 0);
  endtask

  task automatic set_en(bit v);
    cfg_we = 1'b1; cfg_en = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack == 0 && ext_req == 0, "R1 reset outputs", {ack, ext_req}, 0);

    // R1 R2: flag clear after reset, window forwarded
    acc(1'b0, 1'b0, 24'h00E100, 16'h0, 1'b0, 16'h0, "R1 flag clear");

    // R3: enable in same cycle as request -> old value applies
    cfg_we = 1'b1; cfg_en = 1'b1;
    acc(1'b1, 1'b0, 24'h00E000, 16'h1234, 1'b0, 16'h0, "R3 same-edge enable");
    cfg_we = 1'b0;

    // R6: word writes over whole array, odd address half the time
    for (int i = 0; i < 1024; i++) begin
      model[i] = pat(i);
      acc(1'b1, 1'b0, 24'h00E000 + 24'(2*i) + 24'(i % 2), pat(i), 1'b1, 16'h0, "R6 word write");
    end
    for (int i = 0; i < 1024; i++)
      acc(1'b0, 1'b0, 24'h00E000 + 24'(2*i) + 24'((i / 3) % 2), 16'h0, 1'b1, model[i], "R6 word read");

    // R8: byte reads of every byte
    for (int j = 0; j < 2048; j++) begin
      logic [15:0] e;
      e = (j % 2) ? {8'h00, model[j/2][15:8]} : {8'h00, model[j/2][7:0]};
      acc(1'b0, 1'b1, 24'h00E000 + 24'(j), 16'h0, 1'b1, e, "R8 byte read");
    end

    // R7: byte writes, upper data byte must not leak
    for (int j = 0; j < 128; j++) begin
      logic [7:0] v;
      v = 8'(j * 37 + 11);
      if (j % 2) model[j/2][15:8] = v; else model[j/2][7:0] = v;
      acc(1'b1, 1'b1, 24'h00E000 + 24'(j), {8'hA5, v}, 1'b1, 16'h0, "R7 byte write");
    end
    for (int i = 0; i < 64; i++)
      acc(1'b0, 1'b0, 24'h00E000 + 24'(2*i), 16'h0, 1'b1, model[i], "R7 lane check");

    // R2 R4: outside window while enabled
    acc(1'b1, 1'b0, 24'h00DFFE, 16'hBEEF, 1'b0, 16'h0, "R2 below window");
    acc(1'b0, 1'b1, 24'h00E800, 16'h0, 1'b0, 16'h0, "R2 above window");
    acc(1'b1, 1'b1, 24'h01E000, 16'h00C3, 1'b0, 16'h0, "R2 other segment");
    acc(1'b0, 1'b0, 24'hFFE7FE, 16'h0, 1'b0, 16'h0, "R2 high alias");
    acc(1'b0, 1'b0, 24'h00E7FE, 16'h0, 1'b1, model[1023], "R2 top word");

    // R9: requests during a local access are ignored
    req = 1'b1; we = 1'b1; bsel = 1'b0; addr = 24'h00E010; wdata = 16'h7777;
    model[8] = 16'h7777;
    @(negedge clk);
    addr = 24'h00E020; wdata = 16'hDEAD;
    chk(ack == 0, "R9 first cycle ack", 32'(ack), 0);
    @(negedge clk);
    chk(ack == 1 && ext_req == 0, "R9 ack during busy", {ack, ext_req}, 32'h2);
    addr = 24'h004000; wdata = 16'hF00D;
    @(negedge clk);
    req = 1'b0;
    chk(ext_req == 0, "R9 no forward while busy", 32'(ext_req), 0);
    @(negedge clk);
    chk(ext_req == 0 && ack == 0, "R9 idle after", {ack, ext_req}, 0);
    acc(1'b0, 1'b0, 24'h00E020, 16'h0, 1'b1, model[16], "R9 store untouched");
    acc(1'b0, 1'b0, 24'h00E010, 16'h0, 1'b1, 16'h7777, "R9 first write landed");

    // R3: disable in same cycle as request -> still local, next forwarded
    cfg_we = 1'b1; cfg_en = 1'b0;
    acc(1'b0, 1'b0, 24'h00E004, 16'h0, 1'b1, model[2], "R3 same-edge disable");
    cfg_we = 1'b0;
    acc(1'b1, 1'b0, 24'h00E004, 16'h9999, 1'b0, 16'h0, "R3 disabled forward");
    set_en(1'b1);
    acc(1'b0, 1'b0, 24'h00E004, 16'h0, 1'b1, model[2], "R4 contents kept");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule